// File: doc/BRIEF.md
# Mixed-Width Two-Clock RAM with Byte Parity Lanes

This block is a simple dual-port memory: one port only writes, the other only reads, and each runs on its own clock. Either port may be configured as 1, 2, 4, 9, 18 or 36 bits wide, independently of the other. The 9, 18 and 36 bit settings split into 8, 16 or 32 data bits plus one parity bit for each data byte. Both ports see the same array of `DATA_BITS` data bits, so a word written through a narrow port shows up as one slice of a wide word on the other side, and the reverse.

Parity storage only makes sense when both sides carry it. If either port is narrower than a byte, the parity lanes are dropped. In that case parity bits offered on the write side are discarded, and parity pins on the read side return zeros, so the rest of the design can leave them unconnected.

Writes take effect on the write clock edge at which the write enable is high. A read captures the addressed slice into the output register on the read clock edge at which the read enable is high. The output then holds its value until the next enabled read. The block has no reset, no ECC and no cascade path.

Top module: `asym_parity_ram`

## Requirements
- R1: `WR_WIDTH` and `RD_WIDTH` must each be one of 1, 2, 4, 9, 18, 36, and `DATA_BITS` must be a power of two of at least twice the wider data width; any other setting stops elaboration. Each port's address is log2(`DATA_BITS` / that port's data bits) wide, and the top address of each port reaches the last slice of the array.
- R2: A 9, 18 or 36 bit port carries its data on bits [7:0], [15:0] or [31:0] and its parity on the bits above those. Parity bit k travels with data byte k, through slicing and packing alike.
- R3: On the narrower port, the low log2(wide data bits / narrow data bits) address bits select the slice inside a wide word, and address 0 of a word maps to its least significant bits. The remaining address bits select the word.
- R4: When the write port is 1, 2 or 4 bits and the read port is 9, 18 or 36 bits, the read data bits carry the stored data and the read parity bits are always 0.
- R5: When the read port is 1, 2 or 4 bits and the write port is 9, 18 or 36 bits, the write parity bits are discarded and have no effect on any read data.
- R6: A write completes on the single write clock edge at which `wr_en` is 1. With `wr_en` at 0, `wr_addr` and `wr_data` change nothing in the array.
- R7: `rd_data` takes the addressed slice on the read clock edge at which `rd_en` is 1, and it is visible after that edge. While `rd_en` is 0, `rd_data` holds its value whatever `rd_addr` does.
- R8: A write through the narrower port changes only its own data lane and, when parity is kept, its own parity lane. The other lanes of the same wide word keep their contents.
- R9: Before the first enabled read, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable, sampled on `wr_clk` |
| wr_addr | input | log2(DATA_BITS/write data bits) | Write address in units of the write port's data width |
| wr_data | input | WR_WIDTH | Write data, with parity above the data bits for 9/18/36 |
| rd_clk | input | 1 | Read port clock |
| rd_en | input | 1 | Read enable, sampled on `rd_clk` |
| rd_addr | input | log2(DATA_BITS/read data bits) | Read address in units of the read port's data width |
| rd_data | output | RD_WIDTH | Registered read data, with parity above the data bits for 9/18/36 |

## Verification
The bench builds four small instances: byte-wide to 36-bit, 36-bit to byte-wide, nibble to 18-bit, and 18-bit to 2-bit. It fills each one completely and reads every address back. A slice order reversed inside the word, or an off-by-one in the lane index, would scramble the bytes or nibbles within every wide word. A parity lane that does not follow its byte would flip parity bits against the computed pattern. A design that keeps parity when one side is narrower than a byte would show nonzero parity pins on the 18-bit read, or would let the 18-bit writer's parity leak into the 2-bit reads. Targeted checks cover the rest: a masked write must leave the array alone, a single-lane overwrite must keep its neighbours, and an idle read port must ignore address changes. A missing lane mask, a write that ignores its enable, or an output register that follows the address would each break one of those checks.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;

   // Data bits carried by a port of configured width w
   function automatic int port_dw(input int w);
      return (w >= 9) ? (w / 9) * 8 : w;
   endfunction

   // Parity bits carried by a port of configured width w
   function automatic int port_pw(input int w);
      return (w >= 9) ? w / 9 : 0;
   endfunction

   function automatic bit width_ok(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asym_wr_lane.sv
module asym_wr_lane
   import asym_ram_pkg::*;
#(
   parameter int PORT_W   = 9,
   parameter int WIDE_DW  = 32,
   parameter int PAR_W    = 4,
   parameter bit KEEP_PAR = 1'b1,
   parameter int AW       = 8,
   parameter int IDX_W    = 6
)(
   input  logic [AW-1:0]      addr,
   input  logic [PORT_W-1:0]  data,
   output logic [IDX_W-1:0]   idx,
   output logic [WIDE_DW-1:0] dmask,
   output logic [WIDE_DW-1:0] dword,
   output logic [PAR_W-1:0]   pmask,
   output logic [PAR_W-1:0]   pword
);
   localparam int DW    = port_dw(PORT_W);
   localparam int RATIO = WIDE_DW / DW;
   localparam int SEL_W = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam int PW    = KEEP_PAR ? DW / 8 : 1;

   logic [SEL_W-1:0] lane;

   // Word index and data lane placement
   if (RATIO == 1) begin : g_full
      assign lane  = '0;
      assign idx   = addr;
      assign dmask = '1;
      assign dword = data[DW-1:0];
   end else begin : g_slice
      assign lane  = addr[SEL_W-1:0];
      assign idx   = addr[AW-1:SEL_W];
      assign dmask = WIDE_DW'({DW{1'b1}}) << (lane * DW);
      assign dword = WIDE_DW'(data[DW-1:0]) << (lane * DW);
   end

   // Parity lane placement, kept or dropped by width pairing
   if (KEEP_PAR) begin : g_par
      assign pmask = PAR_W'({PW{1'b1}}) << (lane * PW);
      assign pword = PAR_W'(data[PORT_W-1:DW]) << (lane * PW);
   end else if (PORT_W >= 9) begin : g_par_drop
      logic unused_par;
      assign unused_par = ^data[PORT_W-1:DW];
      assign pmask = '0;
      assign pword = '0;
   end else begin : g_no_par
      assign pmask = '0;
      assign pword = '0;
   end

endmodule

// File: rtl/asym_store.sv
module asym_store #(
   parameter int WIDE_DW  = 32,
   parameter int PAR_W    = 4,
   parameter int DEPTH    = 64,
   parameter int IDX_W    = 6,
   parameter bit KEEP_PAR = 1'b1,
   parameter int LANE_DW  = 8
)(
   input  logic               wr_clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [WIDE_DW-1:0] wr_dmask,
   input  logic [WIDE_DW-1:0] wr_dword,
   input  logic [PAR_W-1:0]   wr_pmask,
   input  logic [PAR_W-1:0]   wr_pword,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [WIDE_DW-1:0] rd_dword,
   output logic [PAR_W-1:0]   rd_pword
);
   logic [WIDE_DW-1:0] dmem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) begin
         dmem[wr_idx] <= (dmem[wr_idx] & ~wr_dmask) | (wr_dword & wr_dmask);
      end
   end

   assign rd_dword = dmem[rd_idx];

   if (KEEP_PAR) begin : g_pmem
      logic [PAR_W-1:0] pmem [DEPTH];
      always_ff @(posedge wr_clk) begin
         if (wr_en) begin
            pmem[wr_idx] <= (pmem[wr_idx] & ~wr_pmask) | (wr_pword & wr_pmask);
         end
      end
      assign rd_pword = pmem[rd_idx];
   end else begin : g_no_pmem
      logic unused_pin;
      assign unused_pin = ^{wr_pmask, wr_pword};
      assign rd_pword   = '0;
   end

   // R6
   wr_lane_chk: assert property (@(posedge wr_clk)
      wr_en |=> ((dmem[$past(wr_idx)] & $past(wr_dmask)) == ($past(wr_dword) & $past(wr_dmask))))
      else $error("written lane does not hold the written data");

   // R8
   wr_keep_chk: assert property (@(posedge wr_clk)
      wr_en |=> ((dmem[$past(wr_idx)] & ~$past(wr_dmask)) == ($past(dmem[wr_idx]) & ~$past(wr_dmask))))
      else $error("write disturbed a neighbouring lane");

   // R3
   wr_mask_width_chk: assert property (@(posedge wr_clk)
      wr_en |-> ($countones(wr_dmask) == LANE_DW))
      else $error("write lane mask does not match the write data width");

endmodule

// File: rtl/asym_rd_lane.sv
module asym_rd_lane
   import asym_ram_pkg::*;
#(
   parameter int PORT_W   = 36,
   parameter int WIDE_DW  = 32,
   parameter int PAR_W    = 4,
   parameter bit KEEP_PAR = 1'b1,
   parameter int AW       = 6,
   parameter int IDX_W    = 6
)(
   input  logic               clk,
   input  logic               en,
   input  logic [AW-1:0]      addr,
   input  logic [WIDE_DW-1:0] dword,
   input  logic [PAR_W-1:0]   pword,
   output logic [IDX_W-1:0]   idx,
   output logic [PORT_W-1:0]  data_q
);
   localparam int DW     = port_dw(PORT_W);
   localparam int RATIO  = WIDE_DW / DW;
   localparam int SEL_W  = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam int PW     = KEEP_PAR ? DW / 8 : 1;
   localparam int OUT_PW = PORT_W - DW;

   logic [SEL_W-1:0]  lane;
   logic [DW-1:0]     dsel;
   logic [PORT_W-1:0] nxt;
   logic [PORT_W-1:0] q = '0;

   if (RATIO == 1) begin : g_full
      assign lane = '0;
      assign idx  = addr;
      assign dsel = dword;
   end else begin : g_slice
      assign lane = addr[SEL_W-1:0];
      assign idx  = addr[AW-1:SEL_W];
      assign dsel = DW'(dword >> (lane * DW));
   end

   if (KEEP_PAR) begin : g_par_keep
      logic [PW-1:0] psel;
      assign psel = PW'(pword >> (lane * PW));
      assign nxt  = {psel, dsel};
   end else if (OUT_PW > 0) begin : g_par_zero
      logic unused_pw;
      assign unused_pw = ^pword;
      assign nxt = {{OUT_PW{1'b0}}, dsel};
   end else begin : g_no_par
      logic unused_pw;
      assign unused_pw = ^pword;
      assign nxt = dsel;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         q <= nxt;
      end
   end

   assign data_q = q;

   // R7
   rd_hold_chk: assert property (@(posedge clk)
      !en |=> $stable(data_q))
      else $error("read output moved without a read enable");

endmodule

// File: rtl/asym_parity_ram.sv
module asym_parity_ram
   import asym_ram_pkg::*;
#(
   parameter int  WR_WIDTH  = 9,
   parameter int  RD_WIDTH  = 36,
   parameter int  DATA_BITS = 2048,
   localparam int WR_DW     = port_dw(WR_WIDTH),
   localparam int RD_DW     = port_dw(RD_WIDTH),
   localparam int WAW       = $clog2(DATA_BITS / WR_DW),
   localparam int RAW       = $clog2(DATA_BITS / RD_DW)
)(
   input  logic                wr_clk,
   input  logic                wr_en,
   input  logic [WAW-1:0]      wr_addr,
   input  logic [WR_WIDTH-1:0] wr_data,
   input  logic                rd_clk,
   input  logic                rd_en,
   input  logic [RAW-1:0]      rd_addr,
   output logic [RD_WIDTH-1:0] rd_data
);
   localparam int WIDE_DW  = max2(WR_DW, RD_DW);
   localparam int DEPTH    = DATA_BITS / WIDE_DW;
   localparam int IDX_W    = $clog2(DEPTH);
   localparam bit KEEP_PAR = (port_pw(WR_WIDTH) > 0) && (port_pw(RD_WIDTH) > 0);
   localparam int PAR_W    = KEEP_PAR ? WIDE_DW / 8 : 1;

   // R1
   if (!width_ok(WR_WIDTH) || !width_ok(RD_WIDTH)) begin : cfg_width_chk
      $error("port width must be 1, 2, 4, 9, 18 or 36");
   end

   // R1
   if (((DATA_BITS & (DATA_BITS - 1)) != 0) || (DATA_BITS < 2 * WIDE_DW)) begin : cfg_size_chk
      $error("DATA_BITS must be a power of two of at least two wide words");
   end

   logic [IDX_W-1:0]   wr_idx;
   logic [WIDE_DW-1:0] wr_dmask;
   logic [WIDE_DW-1:0] wr_dword;
   logic [PAR_W-1:0]   wr_pmask;
   logic [PAR_W-1:0]   wr_pword;
   logic [IDX_W-1:0]   rd_idx;
   logic [WIDE_DW-1:0] rd_dword;
   logic [PAR_W-1:0]   rd_pword;

   asym_wr_lane #(
      .PORT_W   (WR_WIDTH),
      .WIDE_DW  (WIDE_DW),
      .PAR_W    (PAR_W),
      .KEEP_PAR (KEEP_PAR),
      .AW       (WAW),
      .IDX_W    (IDX_W)
   ) u_wr_lane (
      .addr  (wr_addr),
      .data  (wr_data),
      .idx   (wr_idx),
      .dmask (wr_dmask),
      .dword (wr_dword),
      .pmask (wr_pmask),
      .pword (wr_pword)
   );

   asym_store #(
      .WIDE_DW  (WIDE_DW),
      .PAR_W    (PAR_W),
      .DEPTH    (DEPTH),
      .IDX_W    (IDX_W),
      .KEEP_PAR (KEEP_PAR),
      .LANE_DW  (WR_DW)
   ) u_store (
      .wr_clk   (wr_clk),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_dmask (wr_dmask),
      .wr_dword (wr_dword),
      .wr_pmask (wr_pmask),
      .wr_pword (wr_pword),
      .rd_idx   (rd_idx),
      .rd_dword (rd_dword),
      .rd_pword (rd_pword)
   );

   asym_rd_lane #(
      .PORT_W   (RD_WIDTH),
      .WIDE_DW  (WIDE_DW),
      .PAR_W    (PAR_W),
      .KEEP_PAR (KEEP_PAR),
      .AW       (RAW),
      .IDX_W    (IDX_W)
   ) u_rd_lane (
      .clk    (rd_clk),
      .en     (rd_en),
      .addr   (rd_addr),
      .dword  (rd_dword),
      .pword  (rd_pword),
      .idx    (rd_idx),
      .data_q (rd_data)
   );

endmodule

// File: tb/asym_parity_ram_bench.sv
module asym_parity_ram_bench;
   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int DBITS       = 256;

   logic wclk = 1'b0;
   logic rclk = 1'b0;
   always #(CLK_PERIOD / 2) wclk = ~wclk;
   always #(RCLK_PERIOD / 2) rclk = ~rclk;

   int n_cmp = 0;
   int n_bad = 0;

   // A: 9-bit write, 36-bit read
   logic        a_wen = 1'b0;
   logic [4:0]  a_waddr = '0;
   logic [8:0]  a_wdata = '0;
   logic        a_ren = 1'b0;
   logic [2:0]  a_raddr = '0;
   logic [35:0] a_rdata;
   // B: 36-bit write, 9-bit read
   logic        b_wen = 1'b0;
   logic [2:0]  b_waddr = '0;
   logic [35:0] b_wdata = '0;
   logic        b_ren = 1'b0;
   logic [4:0]  b_raddr = '0;
   logic [8:0]  b_rdata;
   // C: 4-bit write, 18-bit read
   logic        c_wen = 1'b0;
   logic [5:0]  c_waddr = '0;
   logic [3:0]  c_wdata = '0;
   logic        c_ren = 1'b0;
   logic [3:0]  c_raddr = '0;
   logic [17:0] c_rdata;
   // D: 18-bit write, 2-bit read
   logic        d_wen = 1'b0;
   logic [3:0]  d_waddr = '0;
   logic [17:0] d_wdata = '0;
   logic        d_ren = 1'b0;
   logic [6:0]  d_raddr = '0;
   logic [1:0]  d_rdata;

   asym_parity_ram #(.WR_WIDTH(9), .RD_WIDTH(36), .DATA_BITS(DBITS)) u_asym_parity_ram (
      .wr_clk(wclk), .wr_en(a_wen), .wr_addr(a_waddr), .wr_data(a_wdata),
      .rd_clk(rclk), .rd_en(a_ren), .rd_addr(a_raddr), .rd_data(a_rdata));
   asym_parity_ram #(.WR_WIDTH(36), .RD_WIDTH(9), .DATA_BITS(DBITS)) u_wide_to_byte (
      .wr_clk(wclk), .wr_en(b_wen), .wr_addr(b_waddr), .wr_data(b_wdata),
      .rd_clk(rclk), .rd_en(b_ren), .rd_addr(b_raddr), .rd_data(b_rdata));
   asym_parity_ram #(.WR_WIDTH(4), .RD_WIDTH(18), .DATA_BITS(DBITS)) u_nib_to_half (
      .wr_clk(wclk), .wr_en(c_wen), .wr_addr(c_waddr), .wr_data(c_wdata),
      .rd_clk(rclk), .rd_en(c_ren), .rd_addr(c_raddr), .rd_data(c_rdata));
   asym_parity_ram #(.WR_WIDTH(18), .RD_WIDTH(2), .DATA_BITS(DBITS)) u_half_to_bits (
      .wr_clk(wclk), .wr_en(d_wen), .wr_addr(d_waddr), .wr_data(d_wdata),
      .rd_clk(rclk), .rd_en(d_ren), .rd_addr(d_raddr), .rd_data(d_rdata));

   // Stimulus patterns
   function automatic logic [7:0] pa_byte(input int a);
      return 8'(a * 37 + 5);
   endfunction
   function automatic logic pa_par(input int a);
      return 1'(a ^ (a >> 2));
   endfunction
   function automatic logic [35:0] pa_word(input int r);
      logic [35:0] w = '0;
      for (int k = 0; k < 4; k++) begin
         w[k*8 +: 8] = pa_byte(4 * r + k);
         w[32 + k]   = pa_par(4 * r + k);
      end
      return w;
   endfunction
   function automatic logic [31:0] pb_word(input int w);
      return 32'(w * 32'h01030507) ^ 32'h5AC396E1;
   endfunction
   function automatic logic [3:0] pb_par(input int w);
      return 4'(w * 5 + 3);
   endfunction
   function automatic logic [3:0] pc_nib(input int a);
      return 4'(a * 7 + 3);
   endfunction
   function automatic logic [15:0] pd_half(input int w);
      return 16'(w * 16'h1357) ^ 16'hBEEF;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_a(input int a, input logic [8:0] v);
      @(negedge wclk); a_wen = 1'b1; a_waddr = 5'(a); a_wdata = v;
      @(negedge wclk); a_wen = 1'b0;
   endtask
   task automatic rd_a(input int r);
      @(negedge rclk); a_ren = 1'b1; a_raddr = 3'(r);
      @(negedge rclk); a_ren = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [35:0] exp36;
      logic [31:0] bw;
      logic [15:0] h;
      logic [3:0]  bp;
      #1;
      // R9: outputs are zero before any read
      check("R9", 64'(a_rdata), 64'd0);
      check("R9", 64'(b_rdata), 64'd0);
      check("R9", 64'(c_rdata), 64'd0);
      check("R9", 64'(d_rdata), 64'd0);

      // A: bytes with parity packed into 36-bit words (R2)
      for (int a = 0; a < 32; a++) wr_a(a, {pa_par(a), pa_byte(a)});
      for (int r = 0; r < 8; r++) begin
         rd_a(r);
         check((r == 7) ? "R1" : "R2", 64'(a_rdata), 64'(pa_word(r)));
      end

      // R6: masked write changes nothing
      @(negedge wclk); a_wen = 1'b0; a_waddr = 5'd0; a_wdata = '1;
      repeat (3) @(negedge wclk);
      rd_a(0);
      check("R6", 64'(a_rdata), 64'(pa_word(0)));

      // R7: idle read port holds while the address moves
      rd_a(2);
      @(negedge rclk); a_raddr = 3'd5;
      repeat (3) @(negedge rclk);
      check("R7", 64'(a_rdata), 64'(pa_word(2)));

      // R8: overwrite lane 1 of word 0 only
      wr_a(1, {1'b1, 8'h3C});
      rd_a(0);
      exp36 = pa_word(0);
      exp36[15:8] = 8'h3C;
      exp36[33]   = 1'b1;
      check("R8", 64'(a_rdata), 64'(exp36));

      // B: 36-bit words split into bytes with parity (R3)
      for (int w = 0; w < 8; w++) begin
         @(negedge wclk); b_wen = 1'b1; b_waddr = 3'(w); b_wdata = {pb_par(w), pb_word(w)};
      end
      @(negedge wclk); b_wen = 1'b0;
      for (int a = 0; a < 32; a++) begin
         @(negedge rclk); b_ren = 1'b1; b_raddr = 5'(a);
         @(negedge rclk); b_ren = 1'b0;
         bw = pb_word(a >> 2);
         bp = pb_par(a >> 2);
         check((a == 31) ? "R1" : "R3", 64'(b_rdata), 64'({bp[a & 3], bw[(a & 3) * 8 +: 8]}));
      end

      // C: nibbles into 18-bit reads, parity pins zero (R4)
      for (int a = 0; a < 64; a++) begin
         @(negedge wclk); c_wen = 1'b1; c_waddr = 6'(a); c_wdata = pc_nib(a);
      end
      @(negedge wclk); c_wen = 1'b0;
      for (int r = 0; r < 16; r++) begin
         @(negedge rclk); c_ren = 1'b1; c_raddr = 4'(r);
         @(negedge rclk); c_ren = 1'b0;
         h = '0;
         for (int k = 0; k < 4; k++) h[k*4 +: 4] = pc_nib(4 * r + k);
         check("R4", 64'(c_rdata), 64'({2'b00, h}));
      end

      // D: 18-bit writes with parity set, 2-bit reads unaffected (R5)
      for (int w = 0; w < 16; w++) begin
         @(negedge wclk); d_wen = 1'b1; d_waddr = 4'(w);
         d_wdata = {((w % 2) == 0) ? 2'b11 : 2'b10, pd_half(w)};
      end
      @(negedge wclk); d_wen = 1'b0;
      for (int a = 0; a < 128; a++) begin
         @(negedge rclk); d_ren = 1'b1; d_raddr = 7'(a);
         @(negedge rclk); d_ren = 1'b0;
         h = pd_half(a >> 3);
         check((a == 127) ? "R1" : "R5", 64'(d_rdata), 64'(h[(a & 7) * 2 +: 2]));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule